// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the low address bits for a four-beat burst access. When a new access begins, it captures an external address. The two least significant bits become the starting offset of the burst. The remaining upper bits are held on a separate output for the whole burst. On later clock edges, an active-low advance input steps the burst to its next beat. While advance is inactive, the current beat is held, which creates a wait state.

Two orderings are available, chosen by a static order-select input. Linear order adds the beat number to the starting offset, modulo four. Interleaved order XORs the beat number with the starting offset. After the fourth beat, the sequence wraps to the starting offset and keeps going.

A new access can be started by either of two active-low start strobes. Any start resets the beat number to zero, even in the middle of a burst. The advance input has no effect on the edge that captures the address.

Top module: `burst_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the next edge drives `burst_off` and `upper_addr` to zero.
- R2: On an edge where `start_cpu_n` or `start_ctl_n` is sampled low, `burst_off` takes `addr_in[1:0]` and `upper_addr` takes `addr_in[ADDR_W-1:2]`. Both are visible after that edge.
- R3: With `order_sel` low (linear), each advance edge changes `burst_off` from value v to (v+1) mod 4. For example, start 1 gives 1,2,3,0 and start 3 gives 3,0,1,2.
- R4: With `order_sel` high (interleaved), beat n of a burst with start s drives `burst_off` to s XOR n. For example, start 2 gives 2,3,0,1 and start 3 gives 3,2,1,0.
- R5: After the fourth beat, the next advance returns `burst_off` to the starting offset, and the sequence repeats without stopping.
- R6: On an edge with no start strobe and `adv_n` high, `burst_off` keeps its value.
- R7: On an edge that samples a start strobe low, `adv_n` is ignored. `burst_off` equals the new start offset even when `adv_n` is low.
- R8: A start during an unfinished burst restarts the sequence at beat 0 with the new start offset.
- R9: `upper_addr` changes only on edges that sample a start strobe low. Advance edges and hold edges leave it unchanged, whatever `addr_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External address, captured on a start edge |
| start_cpu_n | input | 1 | Active-low start strobe from the processor side |
| start_ctl_n | input | 1 | Active-low start strobe from the controller side |
| adv_n | input | 1 | Active-low advance to the next beat |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| burst_off | output | 2 | Registered offset of the current beat |
| upper_addr | output | ADDR_W-2 | Registered upper address of the burst |

## Verification
A wrong beat counter or a lost start offset shows up on `burst_off` on the first advance edge after the fault. In interleaved order, each beat gives a distinct value, so a miscount cannot hide for a whole burst. A counter that fails to restart on a mid-burst start is caught at the next beat. A wrong wrap shows one edge after the fourth beat. A corrupted upper register shows on `upper_addr` at once, because the bench changes `addr_in` on every non-start edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 17,
  parameter int OFF_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [ADDR_W-1:0]       addr_in,
  output logic [OFF_W-1:0]        start_d,
  output logic [ADDR_W-OFF_W-1:0] upper_q
);
  localparam int UP_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0] start_q;

  // next-state start offset, used by the output register in the top
  always_comb begin
    start_d = load ? addr_in[OFF_W-1:0] : start_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      upper_q <= '0;
    end else if (load) begin
      start_q <= addr_in[OFF_W-1:0];
      upper_q <= addr_in[ADDR_W-1:OFF_W];
    end
  end

  // R9
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(upper_q));

  // R2
  upper_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> upper_q == $past(addr_in[ADDR_W-1:OFF_W]));

  logic unused_w;
  assign unused_w = ^UP_W;
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  output logic [OFF_W-1:0] cnt_d
);
  logic [OFF_W-1:0] cnt_q;

  // load wins over step: advance is ignored on a start edge
  always_comb begin
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt_q + OFF_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R8
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == '0);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> cnt_q == $past(cnt_q) + OFF_W'(1));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             order_sel,
  input  logic [OFF_W-1:0] start,
  input  logic [OFF_W-1:0] beat,
  output logic [OFF_W-1:0] off
);
  logic [OFF_W-1:0] lin_off;
  logic [OFF_W-1:0] ilv_off;

  assign lin_off = start + beat;

  for (genvar b = 0; b < OFF_W; b++) begin : g_xor
    assign ilv_off[b] = start[b] ^ beat[b];
  end

  always_comb begin
    if (order_e'(order_sel) == ORD_INTERLEAVE) off = ilv_off;
    else                                       off = lin_off;
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              start_cpu_n,
  input  logic              start_ctl_n,
  input  logic              adv_n,
  input  logic              order_sel,
  output logic [1:0]        burst_off,
  output logic [ADDR_W-3:0] upper_addr
);
  localparam int OFF_W = 2;

  logic             load;
  logic             step;
  logic [OFF_W-1:0] start_d;
  logic [OFF_W-1:0] cnt_d;
  logic [OFF_W-1:0] off_d;

  assign load = !start_cpu_n || !start_ctl_n;
  assign step = !adv_n;

  burst_addr_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_areg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .addr_in (addr_in),
    .start_d (start_d),
    .upper_q (upper_addr)
  );

  burst_beat_cnt #(.OFF_W(OFF_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .step  (step),
    .cnt_d (cnt_d)
  );

  burst_order_map #(.OFF_W(OFF_W)) u_map (
    .order_sel (order_sel),
    .start     (start_d),
    .beat      (cnt_d),
    .off       (off_d)
  );

  always_ff @(posedge clk) begin
    if (rst) burst_off <= '0;
    else     burst_off <= off_d;
  end

  // R6
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(burst_off));

  // R7
  off_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> burst_off == $past(addr_in[OFF_W-1:0]));

  // R3
  off_linear_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n && !order_sel) |=>
      (order_sel || burst_off == $past(burst_off) + OFF_W'(1)));
endmodule

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  localparam int ADDR_W = 17;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              start_cpu_n = 1'b1;
  logic              start_ctl_n = 1'b1;
  logic              adv_n = 1'b1;
  logic              order_sel = 1'b0;
  logic [1:0]        burst_off;
  logic [ADDR_W-3:0] upper_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  burst_seq #(.ADDR_W(ADDR_W)) u_burst_seq (
    .clk (clk), .rst (rst), .addr_in (addr_in),
    .start_cpu_n (start_cpu_n), .start_ctl_n (start_ctl_n),
    .adv_n (adv_n), .order_sel (order_sel),
    .burst_off (burst_off), .upper_addr (upper_addr)
  );

  task automatic chk_off(input string req, input logic [1:0] exp);
    n_chk++;
    if (burst_off !== exp) begin
      n_bad++;
      $display("FAIL %s burst_off actual=%0d expected=%0d", req, burst_off, exp);
    end
  endtask

  task automatic chk_up(input string req, input logic [ADDR_W-3:0] exp);
    n_chk++;
    if (upper_addr !== exp) begin
      n_bad++;
      $display("FAIL %s upper_addr actual=%0h expected=%0h", req, upper_addr, exp);
    end
  endtask

  // drive one cycle of inputs, then sample just after the edge
  task automatic cyc(input logic cpu_n, input logic ctl_n, input logic a_n,
                     input logic [ADDR_W-1:0] a);
    start_cpu_n = cpu_n; start_ctl_n = ctl_n; adv_n = a_n; addr_in = a;
    @(posedge clk); #1;
    start_cpu_n = 1'b1; start_ctl_n = 1'b1; adv_n = 1'b1;
  endtask

  function automatic logic [1:0] beat_val(input logic ilv, input logic [1:0] s,
                                          input logic [1:0] n);
    return ilv ? (s ^ n) : (s + n);
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    cyc(1'b1, 1'b1, 1'b1, '1);
    chk_off("R1", 2'd0);
    chk_up("R1", '0);
    rst = 1'b0;
  endtask

  // load, then advance 5 times: covers full order and wrap
  task automatic t_burst(input string req, input logic ilv, input logic use_ctl,
                         input logic [ADDR_W-1:0] a);
    order_sel = ilv;
    if (use_ctl) cyc(1'b1, 1'b0, 1'b1, a);
    else         cyc(1'b0, 1'b1, 1'b1, a);
    chk_off("R2", a[1:0]);
    chk_up("R2", a[ADDR_W-1:2]);
    for (int n = 1; n <= 5; n++) begin
      cyc(1'b1, 1'b1, 1'b0, ~a);
      chk_off(n == 4 ? "R5" : req, beat_val(ilv, a[1:0], 2'(n)));
      chk_up("R9", a[ADDR_W-1:2]);
    end
  endtask

  task automatic t_hold();
    order_sel = 1'b0;
    cyc(1'b0, 1'b1, 1'b1, 17'h00a5d);
    cyc(1'b1, 1'b1, 1'b0, 17'h1ffff);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 1'b1, 1'b1, 17'h12342 + 17'(k));
      chk_off("R6", 2'd2);
      chk_up("R9", 15'h0297);
    end
    cyc(1'b1, 1'b1, 1'b0, 17'h0);
    chk_off("R6", 2'd3);
  endtask

  task automatic t_adv_on_load();
    order_sel = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, 17'h10002);
    chk_off("R7", 2'd2);
    cyc(1'b1, 1'b0, 1'b0, 17'h00001);
    chk_off("R7", 2'd1);
    cyc(1'b1, 1'b1, 1'b0, 17'h0);
    chk_off("R7", 2'd0);
  endtask

  task automatic t_reload();
    order_sel = 1'b1;
    cyc(1'b0, 1'b1, 1'b1, 17'h00003);
    cyc(1'b1, 1'b1, 1'b0, 17'h0);
    cyc(1'b1, 1'b1, 1'b0, 17'h0);
    chk_off("R8", 2'd1);
    cyc(1'b1, 1'b0, 1'b1, 17'h00021);
    chk_off("R8", 2'd1);
    chk_up("R8", 15'h0008);
    cyc(1'b1, 1'b1, 1'b0, 17'h0);
    chk_off("R8", 2'd0);
    cyc(1'b1, 1'b1, 1'b0, 17'h0);
    chk_off("R8", 2'd3);
  endtask

  initial begin
    t_reset();
    t_burst("R3", 1'b0, 1'b0, 17'h1abc1);
    t_burst("R3", 1'b0, 1'b1, 17'h04563);
    t_burst("R4", 1'b1, 1'b0, 17'h0f0f2);
    t_burst("R4", 1'b1, 1'b1, 17'h15553);
    t_hold();
    t_adv_on_load();
    t_reload();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired before all scenarios finished");
    end
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule